// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer

This block runs byte reads against an external asynchronous memory that supports page mode. An internal client hands it one byte address at a time over a valid/ready request port. The sequencer puts the address on a 24-bit bus and pulls chip select and read strobe low. It waits a programmed number of clock cycles, captures the byte from the 8-bit data bus, and returns that byte with a one-cycle response pulse.

When page mode is enabled, the block remembers which page is open. A request that lands in the open page uses the short in-page pulse length. Any other request uses the long first-access pulse length. Requests that arrive back to back form one burst, and both strobes stay low for the whole burst. When an access ends with no request waiting, the strobes are released and the page is forgotten.

Top module: `pgrd_ctrl`

## Requirements
- R1: After reset, mem_cs_n and mem_rd_n are high, rsp_valid is low and req_ready is high.
- R2: With cfg_page_en low, every access lasts the first-access pulse length, even when it falls in the page of the previous access.
- R3: cfg_page_sz selects the page size: 0 gives 4 bytes, 1 gives 8, 2 gives 16 and 3 gives 32. A page is aligned to its own size, so the page number is req_addr[23:2+cfg_page_sz]. In page mode, an access that falls in the open page lasts cfg_next_pulse cycles.
- R4: In page mode, an access lasts cfg_first_pulse cycles when no page is open or when its page number differs from the open page.
- R5: A programmed pulse length of zero is treated as one cycle.
- R6: Suppose a request is accepted at a clock edge and its pulse length is L. The byte on mem_data during the last of the L cycles is returned on rsp_data. rsp_valid is high for exactly the one cycle that follows those L cycles.
- R7: Across back-to-back requests, mem_cs_n and mem_rd_n stay low without a break until the final access of the burst ends.
- R8: mem_cs_n and mem_rd_n always carry the same value.
- R9: If no request is accepted in the last cycle of an access, both strobes go high at the next edge and the open page is dropped. The next access is then a first access.
- R10: req_ready is high when no access is running and in the last cycle of an access. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_en | input | 1 | Enables page-hit tracking |
| cfg_page_sz | input | 2 | Page size code (0:4, 1:8, 2:16, 3:32 bytes) |
| cfg_first_pulse | input | 7 | Cycles for the first access to a page (0 means 1) |
| cfg_next_pulse | input | 7 | Cycles for a later access within the open page (0 means 1) |
| req_valid | input | 1 | A read request is offered |
| req_ready | output | 1 | The request is taken at this edge |
| req_addr | input | 24 | Byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse marking a returned byte |
| rsp_data | output | 8 | Returned byte |
| mem_addr | output | 24 | Address bus to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_data | input | 8 | Data bus from the memory |

## Verification
Take a request accepted at edge A whose access lasts L cycles. Its byte appears with rsp_valid in the cycle that begins at edge A+L. req_ready is next high in the cycle that begins at edge A+L-1. A driver records the accepting edge number and the expected L, which it computes from its own open-page model. A monitor sampling on falling edges then checks that the edge count between acceptance and response equals L exactly. Strobe levels are checked on every falling edge against the outstanding-request queue. After each idle gap, the released strobes are checked several cycles after the burst ends.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 8;
  localparam int PULSE_W = 7;
  localparam int SZ_W    = 2;
  localparam int MIN_OFF = 2;

  // number of byte-offset bits inside a page for a size code
  function automatic int offset_bits(input logic [SZ_W-1:0] sz);
    return MIN_OFF + int'(sz);
  endfunction

  // true when both addresses share a page of the given size
  function automatic logic same_page(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [SZ_W-1:0]   sz);
    logic [ADDR_W-1:0] keep;
    keep = {ADDR_W{1'b1}} << offset_bits(sz);
    return ((a ^ b) & keep) == '0;
  endfunction

  // programmed zero counts as a single cycle
  function automatic logic [PULSE_W-1:0] eff_len(input logic [PULSE_W-1:0] p);
    return (p == '0) ? PULSE_W'(1) : p;
  endfunction
endpackage

// File: rtl/pgrd_page_tracker.sv
module pgrd_page_tracker
  import pgrd_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int SZW = SZ_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           clear,
  input  logic           page_en,
  input  logic [SZW-1:0] page_sz,
  input  logic [AW-1:0]  req_addr,
  output logic           hit
);
  logic          open_valid;
  logic [AW-1:0] open_addr;

  assign hit = page_en && open_valid && same_page(req_addr, open_addr, page_sz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_valid <= 1'b0;
      open_addr  <= '0;
    end else if (capture) begin
      open_valid <= page_en;
      open_addr  <= req_addr;
    end else if (clear) begin
      open_valid <= 1'b0;
    end
  end

  // R9
  clear_drops_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !capture) |=> !open_valid);

  // R2
  no_hit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_en |-> !hit);
endmodule

// File: rtl/pgrd_pulse_timer.sv
module pgrd_pulse_timer
  import pgrd_pkg::*;
#(
  parameter int PW = PULSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] len,
  output logic          active,
  output logic          last
);
  logic [PW-1:0] cnt;

  assign last = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= eff_len(len) - 1'b1;
      active <= 1'b1;
    end else if (last) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5
  zero_len_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len == '0) |=> last);
endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
  import pgrd_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int PW  = PULSE_W,
  parameter int SZW = SZ_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_page_en,
  input  logic [SZW-1:0] cfg_page_sz,
  input  logic [PW-1:0]  cfg_first_pulse,
  input  logic [PW-1:0]  cfg_next_pulse,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_cs_n,
  output logic           mem_rd_n,
  input  logic [DW-1:0]  mem_data
);
  // named internal events
  logic          accept;
  logic          page_hit;
  logic          access_active;
  logic          access_last;
  logic          burst_end;
  logic [PW-1:0] sel_len;

  assign req_ready = !access_active || access_last;
  assign accept    = req_valid && req_ready;
  assign burst_end = access_last && !accept;
  assign sel_len   = page_hit ? cfg_next_pulse : cfg_first_pulse;

  pgrd_page_tracker #(.AW(AW), .SZW(SZW)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .clear    (burst_end),
    .page_en  (cfg_page_en),
    .page_sz  (cfg_page_sz),
    .req_addr (req_addr),
    .hit      (page_hit)
  );

  pgrd_pulse_timer #(.PW(PW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .len    (sel_len),
    .active (access_active),
    .last   (access_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_cs_n <= 1'b1;
      mem_rd_n <= 1'b1;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_cs_n <= 1'b0;
      mem_rd_n <= 1'b0;
    end else if (burst_end) begin
      mem_cs_n <= 1'b1;
      mem_rd_n <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= access_last;
      if (access_last) rsp_data <= mem_data;
    end
  end

  // R6
  rsp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_last |=> rsp_valid);

  // R7
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_active && !access_last) |=> (!mem_cs_n && !mem_rd_n));

  // R9
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (mem_cs_n && mem_rd_n));
endmodule

// File: tb/pgrd_ctrl_tb.sv
module pgrd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_page_en = 1'b0;
  logic [1:0]  cfg_page_sz = 2'd0;
  logic [6:0]  cfg_first_pulse = 7'd5;
  logic [6:0]  cfg_next_pulse = 7'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [23:0] mem_addr;
  logic        mem_cs_n, mem_rd_n;
  logic [7:0]  mem_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit open_v = 0;
  logic [23:0] open_a = '0;
  int q_data[$];
  int q_acc[$];
  int q_len[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural page-mode memory
  function automatic logic [7:0] mem_fn(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  assign mem_data = mem_rd_n ? 8'h00 : mem_fn(mem_addr);

  pgrd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en), .cfg_page_sz(cfg_page_sz),
    .cfg_first_pulse(cfg_first_pulse), .cfg_next_pulse(cfg_next_pulse),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_data(mem_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [6:0] p);
    return (p == 0) ? 1 : int'(p);
  endfunction

  // driver: called at a negedge, returns at a negedge
  task automatic issue(input logic [23:0] a);
    int n;
    bit hit;
    hit = cfg_page_en && open_v &&
          ((a >> (2 + int'(cfg_page_sz))) == (open_a >> (2 + int'(cfg_page_sz))));
    n = hit ? len_of(cfg_next_pulse) : len_of(cfg_first_pulse);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    q_data.push_back(int'(mem_fn(a)));
    q_acc.push_back(cyc);
    q_len.push_back(n);
    open_v = cfg_page_en;
    open_a = a;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: ready only in the last cycle of the access
    check(req_ready == (n == 1), "R10", int'(req_ready), int'(n == 1));
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    while (q_len.size() != 0) @(negedge clk);
    repeat (n) @(negedge clk);
    open_v = 0;
    // R9: strobes released after a burst
    check(mem_cs_n && mem_rd_n, "R9", int'({mem_cs_n, mem_rd_n}), 3);
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R8
      if (mem_cs_n !== mem_rd_n) check(0, "R8", int'(mem_cs_n), int'(mem_rd_n));
      // R7: strobes low while an accepted request is outstanding
      if (q_len.size() > 1 || (q_len.size() == 1 && !rsp_valid))
        if (mem_rd_n !== 1'b0) check(0, "R7", int'(mem_rd_n), 0);
      if (rsp_valid) begin
        if (q_len.size() == 0) begin
          check(0, "R6 unexpected response", 1, 0);
        end else begin
          int d, ac, ln;
          d = q_data.pop_front();
          ac = q_acc.pop_front();
          ln = q_len.pop_front();
          check(int'(rsp_data) == d, "R6 data", int'(rsp_data), d);
          check(cyc - ac == ln, "R3/R4/R5/R2 access cycles", cyc - ac, ln);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_cs_n && mem_rd_n, "R1 strobes", int'({mem_cs_n, mem_rd_n}), 3);
    check(!rsp_valid, "R1 rsp_valid", int'(rsp_valid), 0);
    check(req_ready, "R1 req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: page mode off, every access long
    cfg_page_en = 0; cfg_page_sz = 2'd3;
    issue(24'h000100); issue(24'h000101); issue(24'h000102);
    idle(4);

    // R3/R4: 4-byte pages
    cfg_page_en = 1; cfg_page_sz = 2'd0;
    issue(24'h000100); issue(24'h000101); issue(24'h000103);
    issue(24'h000104); issue(24'h000105);
    idle(4);

    // R3/R4: 32-byte pages, boundary crossing
    cfg_page_sz = 2'd3;
    issue(24'h00011E); issue(24'h00011F); issue(24'h000120); issue(24'h00013F);
    idle(3);
    // R9: page dropped after the gap
    issue(24'h00013F); issue(24'h000121);
    idle(3);

    // R3: 8- and 16-byte pages, upper address bits
    cfg_page_sz = 2'd1;
    issue(24'hA50200); issue(24'hA50207); issue(24'hA50208); issue(24'h5A0208);
    idle(3);
    cfg_page_sz = 2'd2;
    issue(24'h000300); issue(24'h00030F); issue(24'h000310);
    idle(3);

    // R5: zero pulse lengths
    cfg_first_pulse = 7'd0; cfg_next_pulse = 7'd0;
    issue(24'h000400); issue(24'h000401); issue(24'h000500);
    idle(3);
    cfg_first_pulse = 7'd3;
    issue(24'h000600); issue(24'h000601); issue(24'h000602);
    idle(3);

    done = 1;
    check(q_len.size() == 0, "R6 all responses", q_len.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule